// File: doc/BRIEF.md
# Split-Phase Set-Associative Data Cache Lookup

This block is the lookup path of a level-one data cache that starts selecting a set before the address has been translated. The requester supplies only the word-aligned page-offset bits of a virtual address. These bits are the same in the virtual and the physical address, so they select one of 128 sets and one word inside a 32-byte line straight away. In the following cycle a translation port supplies the 20-bit physical page number. That number is compared against the stored tags of all four ways of the selected set. The same port can instead report a translation fault.

A hit returns the addressed 32-bit word. A miss raises a line-sized request to the next memory level and waits for the whole 256-bit line to return. It then writes the line into a victim way and replays the original access as a hit. An invalid way is filled before any valid way. When the set is full, a three-bit pseudo-LRU tree per set picks the victim. The block accepts one access at a time and takes a new request only when idle.

Top module: `vipt_l1_dcache`

## Requirements
- R1: While reset is low and right after it is released, all lines are invalid, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: An access is taken at a clock edge where `req_valid` and `req_ready` are both 1. `req_page_word[11:5]` is the set index and `req_page_word[4:2]` is the word within the line. `xlat_ppn` and `xlat_fault` are sampled at the next edge only, and their values at any other time have no effect.
- R3: If a valid way of the set holds a tag equal to the sampled `xlat_ppn`, then `rsp_valid` is 1 for exactly one cycle after that sampling edge, with `rsp_hit`=1, `rsp_fault`=0 and no memory request. `rsp_data` is bits [32*w+31:32*w] of the stored line, where w is the word index.
- R4: If no way matches, `mem_req_valid` rises after the sampling edge with `mem_req_addr` = {ppn, set, 5'b0}. Both stay unchanged until an edge where `mem_rsp_valid` is 1. No response is given and `req_ready` stays 0 meanwhile.
- R5: At the edge where `mem_rsp_valid` is seen, the 256-bit `mem_rsp_line` is written to the victim way and marked valid, and `mem_req_valid` drops. One edge later, `rsp_valid` is 1 with `rsp_hit`=1 and the requested word. Later accesses to that line hit.
- R6: If `xlat_fault` is 1 at the sampling edge, `rsp_valid` is 1 one cycle later with `rsp_fault`=1, `rsp_hit`=0 and `rsp_data`=0. No memory request is made, and the contents and replacement state of the cache are left as they were.
- R7: On a miss in a set with an invalid way, the lowest-numbered invalid way is filled, and no valid line is evicted.
- R8: In a full set, the victim follows a tree of bits b0..b2 that starts at 0 after reset. If b0=1 the victim is way 2+b2, otherwise way b1. Every hit and every refill of way w sets b0 to NOT w[1]. It sets b1 to NOT w[0] when w<2, and b2 to NOT w[0] when w>=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_ready | output | 1 | Block is idle and can take an access |
| req_page_word | input | 10 | Virtual page-offset bits 11:2 (set and word index) |
| xlat_ppn | input | 20 | Translated physical page number, one cycle after request |
| xlat_fault | input | 1 | Translation fault, sampled together with `xlat_ppn` |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response carries valid data |
| rsp_fault | output | 1 | Response reports a translation fault |
| rsp_data | output | 32 | Addressed word |
| mem_req_valid | output | 1 | Line fetch request to next level, held until served |
| mem_req_addr | output | 32 | Line-aligned physical address of the fetch |
| mem_rsp_valid | input | 1 | Line returned from next level |
| mem_rsp_line | input | 256 | Returned line, word w in bits 32w+31:32w |

## Verification
Random accesses are confined to two sets and six page numbers. This forces frequent evictions from full sets, and the pseudo-LRU choice of victim is then seen as a later hit or miss. Random translation faults and random refill latencies separate a fault from a hit and from a miss, and show that the fill request stays steady while it waits. Directed sequences fill a set one way at a time to expose the invalid-first rule. They then touch one way and force an eviction, which tells a correct tree from a mere round-robin. Faults on both a resident and an absent line show that a fault changes neither contents nor replacement state.

// File: rtl/vipt_cache_pkg.sv
package vipt_cache_pkg;

    typedef enum logic [1:0] {
        C_IDLE   = 2'd0,
        C_LOOK   = 2'd1,
        C_MISS   = 2'd2,
        C_REPLAY = 2'd3
    } cstate_e;

endpackage

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        check_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
    input  logic [WAYS-1:0]             valid_i,
    input  logic [TAG_W-1:0]            ppn_i,
    output logic [WAYS-1:0]             hit_vec_o,
    output logic                        hit_o,
    output logic [$clog2(WAYS)-1:0]     hit_way_o
);
    localparam int WAY_W = $clog2(WAYS);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec_o[w] = valid_i[w] && (tags_i[w] == ppn_i);
    end

    always_comb begin
        hit_way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec_o[w]) hit_way_o = WAY_W'(w);
        end
    end

    assign hit_o = |hit_vec_o;

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        check_i |-> $onehot0(hit_vec_o)); // R3

endmodule

// File: rtl/vipt_plru.sv
module vipt_plru #(
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     check_i,
    input  logic [WAYS-2:0]          tree_i,
    input  logic [WAYS-1:0]          valid_i,
    input  logic [$clog2(WAYS)-1:0]  touch_i,
    output logic [$clog2(WAYS)-1:0]  victim_o,
    output logic [WAYS-2:0]          tree_o
);
    localparam int WAY_W = $clog2(WAYS);

    logic             inv_found;
    logic [WAY_W-1:0] inv_way;
    logic [WAY_W-1:0] tree_way;

    // victim: lowest invalid way, otherwise walk the tree
    always_comb begin
        logic [WAY_W-1:0] node;
        logic             b;
        inv_found = 1'b0;
        inv_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
        end
        node     = '0;
        tree_way = '0;
        for (int l = 0; l < WAY_W; l++) begin
            b        = tree_i[node];
            tree_way = (tree_way << 1) | WAY_W'(b);
            node     = WAY_W'(2 * int'(node) + 1 + int'(b));
        end
        victim_o = inv_found ? inv_way : tree_way;
    end

    // update: point every node on the path away from the touched way
    always_comb begin
        logic [WAY_W-1:0] node;
        logic [WAY_W-1:0] tw;
        logic             b;
        tree_o = tree_i;
        node   = '0;
        tw     = touch_i;
        for (int l = 0; l < WAY_W; l++) begin
            b            = tw[WAY_W-1];
            tree_o[node] = ~b;
            tw           = tw << 1;
            node         = WAY_W'(2 * int'(node) + 1 + int'(b));
        end
    end

    AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (check_i && !(&valid_i)) |-> !valid_i[victim_o]); // R7

endmodule

// File: rtl/vipt_l1_dcache.sv
module vipt_l1_dcache
    import vipt_cache_pkg::*;
#(
    parameter int TAG_W  = 20,
    parameter int SET_W  = 7,
    parameter int OFF_W  = 5,
    parameter int WAYS   = 4,
    parameter int WORD_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [SET_W+OFF_W-1:2]         req_page_word,
    input  logic [TAG_W-1:0]               xlat_ppn,
    input  logic                           xlat_fault,
    output logic                           rsp_valid,
    output logic                           rsp_hit,
    output logic                           rsp_fault,
    output logic [WORD_W-1:0]              rsp_data,
    output logic                           mem_req_valid,
    output logic [TAG_W+SET_W+OFF_W-1:0]   mem_req_addr,
    input  logic                           mem_rsp_valid,
    input  logic [(8<<OFF_W)-1:0]          mem_rsp_line
);
    localparam int PAGE_W = SET_W + OFF_W;
    localparam int BYTE_W = 2;
    localparam int IDX_W  = PAGE_W - BYTE_W;
    localparam int LINE_W = 8 << OFF_W;
    localparam int WSEL_W = OFF_W - BYTE_W;
    localparam int SETS   = 1 << SET_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LOC_W  = SET_W + WAY_W;

    typedef struct packed {
        cstate_e           state;
        logic [IDX_W-1:0]  pw;
        logic [TAG_W-1:0]  ppn;
        logic [WAY_W-1:0]  fill_way;
        logic              mreq;
        logic              rvalid;
        logic              rhit;
        logic              rfault;
        logic [WORD_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    // storage arrays
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-2:0]   plru_q  [SETS];
    logic [TAG_W-1:0]  tag_mem [SETS*WAYS];
    logic [LINE_W-1:0] data_mem[SETS*WAYS];

    logic [SET_W-1:0]             set_idx;
    logic [WSEL_W-1:0]            wsel;
    logic [WAYS-1:0][TAG_W-1:0]   rd_tags;
    logic [TAG_W-1:0]             cmp_ppn;
    logic                         lookup;
    logic [WAYS-1:0]              hit_vec;
    logic                         hit;
    logic [WAY_W-1:0]             hit_way;
    logic [WAY_W-1:0]             victim;
    logic [WAYS-2:0]              tree_upd;
    logic [LINE_W-1:0]            hit_line;
    logic [WORD_W-1:0]            hit_word;
    logic                         fill_en;
    logic                         touch_en;

    assign set_idx = st_q.pw[IDX_W-1:WSEL_W];
    assign wsel    = st_q.pw[WSEL_W-1:0];
    assign lookup  = (st_q.state == C_LOOK) || (st_q.state == C_REPLAY);
    assign cmp_ppn = (st_q.state == C_LOOK) ? xlat_ppn : st_q.ppn;

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tags[w] = tag_mem[{set_idx, WAY_W'(w)}];
    end

    vipt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .check_i   (lookup),
        .tags_i    (rd_tags),
        .valid_i   (valid_q[set_idx]),
        .ppn_i     (cmp_ppn),
        .hit_vec_o (hit_vec),
        .hit_o     (hit),
        .hit_way_o (hit_way)
    );

    vipt_plru #(.WAYS(WAYS)) i_plru (
        .clk      (clk),
        .rst_n    (rst_n),
        .check_i  (lookup),
        .tree_i   (plru_q[set_idx]),
        .valid_i  (valid_q[set_idx]),
        .touch_i  (hit_way),
        .victim_o (victim),
        .tree_o   (tree_upd)
    );

    assign hit_line = data_mem[{set_idx, hit_way}];
    assign hit_word = hit_line[wsel*WORD_W +: WORD_W];

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.rhit   = 1'b0;
        st_d.rfault = 1'b0;
        st_d.rdata  = '0;
        fill_en     = 1'b0;
        touch_en    = 1'b0;
        unique case (st_q.state)
            C_IDLE: begin
                if (req_valid) begin
                    st_d.pw    = req_page_word;
                    st_d.state = C_LOOK;
                end
            end
            C_LOOK: begin
                if (xlat_fault) begin
                    st_d.rvalid = 1'b1;
                    st_d.rfault = 1'b1;
                    st_d.state  = C_IDLE;
                end else if (hit) begin
                    st_d.rvalid = 1'b1;
                    st_d.rhit   = 1'b1;
                    st_d.rdata  = hit_word;
                    st_d.state  = C_IDLE;
                    touch_en    = 1'b1;
                end else begin
                    st_d.ppn      = xlat_ppn;
                    st_d.fill_way = victim;
                    st_d.mreq     = 1'b1;
                    st_d.state    = C_MISS;
                end
            end
            C_MISS: begin
                if (mem_rsp_valid) begin
                    fill_en    = 1'b1;
                    st_d.mreq  = 1'b0;
                    st_d.state = C_REPLAY;
                end
            end
            C_REPLAY: begin
                st_d.rvalid = 1'b1;
                st_d.rhit   = hit;
                st_d.rdata  = hit_word;
                st_d.state  = C_IDLE;
                touch_en    = hit;
            end
            default: st_d.state = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= C_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                plru_q[s]  <= '0;
            end
        end else begin
            if (fill_en) valid_q[set_idx][st_q.fill_way] <= 1'b1;
            if (touch_en) plru_q[set_idx] <= tree_upd;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_mem[LOC_W'({set_idx, st_q.fill_way})]  <= st_q.ppn;
            data_mem[LOC_W'({set_idx, st_q.fill_way})] <= mem_rsp_line;
        end
    end

    assign req_ready     = (st_q.state == C_IDLE);
    assign rsp_valid     = st_q.rvalid;
    assign rsp_hit       = st_q.rhit;
    assign rsp_fault     = st_q.rfault;
    assign rsp_data      = st_q.rdata;
    assign mem_req_valid = st_q.mreq;
    assign mem_req_addr  = {st_q.ppn, set_idx, OFF_W'(0)};

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (!rsp_hit && !mem_req_valid)); // R6

    AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr))); // R4

    AST_BUSY_WHILE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (!req_ready && !rsp_valid)); // R4

    AST_REFILL_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_rsp_valid) |-> ##2 (rsp_valid && rsp_hit)); // R5

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R3

endmodule

// File: tb/test_vipt_l1_dcache.sv
module test_vipt_l1_dcache;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic         req_ready;
    logic [11:2]  req_page_word;
    logic [19:0]  xlat_ppn;
    logic         xlat_fault;
    logic         rsp_valid, rsp_hit, rsp_fault;
    logic [31:0]  rsp_data;
    logic         mem_req_valid;
    logic [31:0]  mem_req_addr;
    logic         mem_rsp_valid;
    logic [255:0] mem_rsp_line;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vipt_l1_dcache i_vipt_l1_dcache (
        .clk, .rst_n, .req_valid, .req_ready, .req_page_word,
        .xlat_ppn, .xlat_fault, .rsp_valid, .rsp_hit, .rsp_fault, .rsp_data,
        .mem_req_valid, .mem_req_addr, .mem_rsp_valid, .mem_rsp_line
    );

    // reference state taken from the requirements
    bit        mv [128][4];
    bit [19:0] mt [128][4];
    bit [2:0]  mp [128];

    function automatic logic [31:0] mem_word(input logic [19:0] ppn, input int s, input int w);
        return {ppn[11:0], 7'(s), 3'(w), 10'h2A5};
    endfunction

    function automatic logic [255:0] mem_line(input logic [19:0] ppn, input int s);
        logic [255:0] l;
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = mem_word(ppn, s, w);
        return l;
    endfunction

    function automatic int ref_victim(input int s);
        for (int w = 0; w < 4; w++) if (!mv[s][w]) return w;
        return mp[s][0] ? (mp[s][2] ? 3 : 2) : (mp[s][1] ? 1 : 0);
    endfunction

    function automatic void ref_touch(input int s, input int w);
        mp[s][0] = (w < 2);
        if (w < 2) mp[s][1] = (w == 0);
        else       mp[s][2] = (w == 2);
    endfunction

    function automatic int ref_lookup(input int s, input logic [19:0] ppn);
        for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == ppn) return w;
        return -1;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic access(input int s, input int w, input logic [19:0] ppn,
                          input bit fault, input int delay, input string tag);
        int way;
        logic [31:0] exp_addr;
        way = ref_lookup(s, ppn);
        exp_addr = {ppn, 7'(s), 5'b0};
        @(negedge clk);
        check(req_ready == 1'b1, "R2", "ready when idle", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R3", "response is one pulse", 32'(rsp_valid), 32'd0);
        req_valid     = 1'b1;
        req_page_word = {7'(s), 3'(w)};
        @(negedge clk);
        req_valid     = 1'b0;
        req_page_word = 10'($urandom);
        xlat_ppn      = ppn;
        xlat_fault    = fault;
        @(negedge clk);
        xlat_ppn   = 20'($urandom);
        xlat_fault = 1'($urandom);
        if (fault) begin
            check(rsp_valid && rsp_fault && !rsp_hit && rsp_data == 0, "R6",
                  "fault response", {rsp_valid, rsp_fault, rsp_hit, rsp_data[28:0]}, 32'hC0000000);
            check(!mem_req_valid, "R6", "no fetch on fault", 32'(mem_req_valid), 32'd0);
        end else if (way >= 0) begin
            check(rsp_valid && rsp_hit && !rsp_fault, {tag, "/R3"}, "hit flags",
                  {rsp_valid, rsp_hit, rsp_fault}, 32'd6);
            check(rsp_data == mem_word(ppn, s, w), {tag, "/R3"}, "hit data",
                  rsp_data, mem_word(ppn, s, w));
            check(!mem_req_valid, {tag, "/R3"}, "no fetch on hit", 32'(mem_req_valid), 32'd0);
            ref_touch(s, way);
        end else begin
            way = ref_victim(s);
            check(mem_req_valid && !rsp_valid, {tag, "/R4"}, "miss raises fetch",
                  {mem_req_valid, rsp_valid}, 32'd2);
            check(mem_req_addr == exp_addr, {tag, "/R4"}, "fetch address", mem_req_addr, exp_addr);
            for (int d = 0; d < delay; d++) begin
                @(negedge clk);
                check(mem_req_valid && mem_req_addr == exp_addr && !req_ready, "R4",
                      "fetch held", mem_req_addr, exp_addr);
            end
            mem_rsp_valid = 1'b1;
            mem_rsp_line  = mem_line(ppn, s);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_line  = '0;
            check(!mem_req_valid && !rsp_valid, "R5", "fetch dropped",
                  {mem_req_valid, rsp_valid}, 32'd0);
            @(negedge clk);
            check(rsp_valid && rsp_hit && rsp_data == mem_word(ppn, s, w), "R5", "replay word",
                  rsp_data, mem_word(ppn, s, w));
            mv[s][way] = 1'b1;
            mt[s][way] = ppn;
            ref_touch(s, way);
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        rst_n = 1'b0; req_valid = 1'b0; req_page_word = '0;
        xlat_ppn = '0; xlat_fault = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_line = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req_valid, "R1", "reset outputs",
              {req_ready, rsp_valid, mem_req_valid}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req_valid, "R1", "after reset",
              {req_ready, rsp_valid, mem_req_valid}, 32'd4);

        // R1: first access after reset misses; R7: invalid ways fill in order
        access(20, 3, 20'h11111, 0, 0, "R1");
        access(20, 5, 20'h22222, 0, 2, "R7");
        access(20, 0, 20'h11111, 0, 0, "R7");
        access(20, 7, 20'h22222, 0, 0, "R7");
        access(20, 1, 20'h33333, 0, 1, "R7");
        access(20, 2, 20'h44444, 0, 0, "R7");
        // R8: touch way 0 then force eviction, evicted line must miss
        access(20, 4, 20'h11111, 0, 0, "R8");
        access(20, 6, 20'h55555, 0, 3, "R8");
        access(20, 6, 20'h33333, 0, 0, "R8");
        access(20, 6, 20'h11111, 0, 0, "R8");
        // R6: fault on absent line, then it still misses; fault on resident line
        access(40, 2, 20'h66666, 1, 0, "R6");
        access(40, 2, 20'h66666, 0, 0, "R6");
        access(40, 3, 20'h66666, 1, 0, "R6");
        access(40, 3, 20'h66666, 0, 0, "R6");
        // random traffic over two sets and six pages
        for (int i = 0; i < 400; i++) begin
            int s;
            logic [19:0] p;
            s = ($urandom % 2 == 0) ? 5 : 127;
            p = 20'h0A000 + 20'(($urandom % 6) * 13 + 1);
            access(s, int'($urandom % 8), p, ($urandom % 10) == 0, int'($urandom % 4), "R8");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule